// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, for each memory access made on several buses at once, whether the access is allowed. It holds a small set of programmable protection regions. Each region has a base address, a size that is a power of two, an enable bit and four permission bits that grant read and write access separately to privileged and unprivileged code. The address, direction and privilege of each access are checked against every enabled region in the same cycle. The allow result for each bus is combinational. When any valid access is refused, the checker records its address, its direction and the bus that issued it in a fault register one cycle later.

Regions may overlap. When they do, the region with the larger index decides the outcome. An access that hits no region is refused unless it is privileged and the background map enable is set. With the unit enable low, every access is allowed and no fault is recorded. Software clears the fault register with a one-cycle pulse. Until that pulse arrives, the register keeps the first fault and ignores later ones.

Top module: `prot_region_checker`

## Requirements
- R1: Region `cfg_idx` (0 to NREG-1, default 8 regions) is loaded on a clock edge with `cfg_we` high. Its size is 2^`cfg_size` bytes, and a code below 5 is treated as 5, which gives 32 bytes.
- R2: An address matches an enabled region when all address bits at and above bit `cfg_size` equal those of the region base. The low bits of the stored base are ignored.
- R3: When several enabled regions match, only the permissions of the highest-indexed match apply.
- R4: The permission bits are: bit 0 allows privileged reads, bit 1 allows privileged writes, bit 2 allows unprivileged reads and bit 3 allows unprivileged writes. A write has `acc_wr` = 1 and a privileged access has `acc_priv` = 1.
- R5: A region whose two write bits are clear is read-only, and any write that it decides is refused.
- R6: An access that matches no region is allowed only when it is privileged and `bg_en` is 1. Otherwise it is refused.
- R7: While `mpu_en` is 0, `allow` is all ones and no fault is captured.
- R8: One cycle after a valid access with `allow` low, `fault_valid` is 1 and `fault_addr`, `fault_wr` and `fault_port` describe that access. When several buses fault in the same cycle, the lowest-numbered bus is recorded.
- R9: A captured fault holds its contents against later faults until `fault_clr` is pulsed. A pulse with no new fault in that cycle clears `fault_valid`. A pulse that coincides with a new fault records the new fault.
- R10: After reset, all regions are disabled and `fault_valid` is 0.
- R11: Each bus is judged independently in the same cycle, and `allow[p]` depends only on the inputs of bus p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mpu_en | input | 1 | Protection enable |
| bg_en | input | 1 | Background map for privileged accesses |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 3 | Region index to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | log2 of region size in bytes |
| cfg_en | input | 1 | Region enable |
| cfg_perm | input | 4 | Region permission bits |
| acc_valid | input | 3 | Per-bus access valid |
| acc_addr | input | 96 | Per-bus address, bus p at bits [32p+31:32p] |
| acc_wr | input | 3 | Per-bus write flag |
| acc_priv | input | 3 | Per-bus privileged flag |
| allow | output | 3 | Per-bus access allowed |
| fault_clr | input | 1 | Clears the fault register |
| fault_valid | output | 1 | A fault is held |
| fault_addr | output | 32 | Address of the held fault |
| fault_wr | output | 1 | Direction of the held fault |
| fault_port | output | 2 | Bus that caused the held fault |

## Verification
The assertions run on every cycle. They check that the disabled unit allows everything, that a refused valid access always raises a fault when none is held, that a fault never appears without a refused access, that a held fault keeps its address until it is cleared, and that a clear with no new fault empties the register. The bench scenarios are needed for the rest. These are the region arithmetic (size clamping, upper-bit matching, boundary addresses), the winner among overlapping regions, the meaning of each permission bit, the background map, and which bus is recorded when several fault together.

// File: rtl/prot_region_checker.sv
module prot_region_checker #(
  parameter int NREG  = 8,
  parameter int NP    = 3,
  parameter int AW    = 32,
  parameter int MINSZ = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mpu_en,
  input  logic                    bg_en,
  input  logic                    cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_idx,
  input  logic [AW-1:0]           cfg_base,
  input  logic [$clog2(AW)-1:0]   cfg_size,
  input  logic                    cfg_en,
  input  logic [3:0]              cfg_perm,
  input  logic [NP-1:0]           acc_valid,
  input  logic [NP*AW-1:0]        acc_addr,
  input  logic [NP-1:0]           acc_wr,
  input  logic [NP-1:0]           acc_priv,
  output logic [NP-1:0]           allow,
  input  logic                    fault_clr,
  output logic                    fault_valid,
  output logic [AW-1:0]           fault_addr,
  output logic                    fault_wr,
  output logic [$clog2(NP)-1:0]   fault_port
);
  localparam int SW = $clog2(AW);
  localparam int PW = $clog2(NP);
  localparam logic [SW-1:0] MINV = SW'(MINSZ);

  logic [AW-1:0] reg_base [NREG];
  logic [AW-1:0] reg_mask [NREG];
  logic [3:0]    reg_perm [NREG];
  logic [NREG-1:0] reg_en;

  logic [SW-1:0] sz_eff;
  assign sz_eff = (cfg_size < MINV) ? MINV : cfg_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_en <= '0;
      for (int r = 0; r < NREG; r++) begin
        reg_base[r] <= '0;
        reg_mask[r] <= '0;
        reg_perm[r] <= '0;
      end
    end else if (cfg_we && (int'(cfg_idx) < NREG)) begin
      reg_en[cfg_idx]   <= cfg_en;
      reg_mask[cfg_idx] <= {AW{1'b1}} << sz_eff;
      reg_base[cfg_idx] <= cfg_base & ({AW{1'b1}} << sz_eff);
      reg_perm[cfg_idx] <= cfg_perm;
    end
  end

  logic [NP-1:0] hit;
  logic [3:0]    win_perm [NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      hit[p] = 1'b0;
      win_perm[p] = 4'b0;
      for (int r = 0; r < NREG; r++) begin
        if (reg_en[r] && (((acc_addr[p*AW +: AW] ^ reg_base[r]) & reg_mask[r]) == '0)) begin
          hit[p] = 1'b1;
          win_perm[p] = reg_perm[r];
        end
      end
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_port
      assign allow[gp] = !mpu_en ? 1'b1
                       : hit[gp] ? win_perm[gp][{~acc_priv[gp], acc_wr[gp]}]
                       : (acc_priv[gp] & bg_en);
    end
  endgenerate

  logic [NP-1:0] refused;
  assign refused = acc_valid & ~allow;

  logic [PW-1:0] first_p;
  always_comb begin
    first_p = '0;
    for (int p = NP - 1; p >= 0; p--)
      if (refused[p]) first_p = PW'(p);
  end

  logic take;
  assign take = (|refused) && (fault_clr || !fault_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_valid <= 1'b0;
      fault_addr  <= '0;
      fault_wr    <= 1'b0;
      fault_port  <= '0;
    end else if (take) begin
      fault_valid <= 1'b1;
      fault_addr  <= acc_addr[first_p*AW +: AW];
      fault_wr    <= acc_wr[first_p];
      fault_port  <= first_p;
    end else if (fault_clr) begin
      fault_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_region_sva.sv
module prot_region_sva #(
  parameter int NP = 3,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mpu_en,
  input logic [NP-1:0] acc_valid,
  input logic [NP-1:0] allow,
  input logic          fault_clr,
  input logic          fault_valid,
  input logic [AW-1:0] fault_addr
);
  assert_disabled_allows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mpu_en |-> (allow == {NP{1'b1}}));

  assert_refusal_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_valid && |(acc_valid & ~allow)) |=> fault_valid);

  assert_fault_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_valid) |-> $past(|(acc_valid & ~allow)));

  assert_fault_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_clr) |=> (fault_valid && $stable(fault_addr)));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !(|(acc_valid & ~allow))) |=> !fault_valid);
endmodule

bind prot_region_checker prot_region_sva #(.NP(NP), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .mpu_en(mpu_en), .acc_valid(acc_valid),
  .allow(allow), .fault_clr(fault_clr), .fault_valid(fault_valid),
  .fault_addr(fault_addr)
);

// File: tb/prot_region_checker_tb.sv
module prot_region_checker_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, mpu_en, bg_en, cfg_we, cfg_en, fault_clr;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [4:0]  cfg_size;
  logic [3:0]  cfg_perm;
  logic [2:0]  acc_valid, acc_wr, acc_priv, allow;
  logic [95:0] acc_addr;
  logic        fault_valid, fault_wr;
  logic [31:0] fault_addr;
  logic [1:0]  fault_port;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  prot_region_checker u_dut (
    .clk(clk), .rst_n(rst_n), .mpu_en(mpu_en), .bg_en(bg_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_en(cfg_en), .cfg_perm(cfg_perm), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_priv(acc_priv), .allow(allow), .fault_clr(fault_clr),
    .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_wr(fault_wr),
    .fault_port(fault_port)
  );

  // {addr, wr, priv, expected allow}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {32'h0000_0010, 1'b0, 1'b0, 1'b1},
    {32'h0000_0010, 1'b1, 1'b0, 1'b1},
    {32'h0000_1004, 1'b1, 1'b1, 1'b0},
    {32'h0000_1004, 1'b0, 1'b0, 1'b1},
    {32'h0000_1804, 1'b1, 1'b0, 1'b1},
    {32'h0000_17FC, 1'b1, 1'b0, 1'b0},
    {32'h2000_00FF, 1'b1, 1'b1, 1'b1},
    {32'h2000_00FF, 1'b0, 1'b0, 1'b0},
    {32'h2000_0100, 1'b0, 1'b1, 1'b0},
    {32'h4000_001F, 1'b0, 1'b1, 1'b1},
    {32'h4000_0020, 1'b0, 1'b1, 1'b0},
    {32'h5000_001F, 1'b1, 1'b0, 1'b1},
    {32'h5000_0020, 1'b1, 1'b0, 1'b0},
    {32'h0001_0000, 1'b0, 1'b1, 1'b0}
  };
  localparam string VREQ [NV] = '{"R2", "R2", "R5", "R4", "R3", "R3", "R4",
                                  "R4", "R6", "R2", "R2", "R1", "R1", "R2"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [31:0] base, input logic [4:0] sz,
                     input logic [3:0] perm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = sz;
    cfg_en = 1'b1; cfg_perm = perm;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input int p, input logic v, input logic [31:0] a,
                       input logic w, input logic pr);
    acc_valid[p] = v; acc_addr[p*32 +: 32] = a; acc_wr[p] = w; acc_priv[p] = pr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mpu_en = 1'b1; bg_en = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0;
    cfg_idx = '0; cfg_base = '0; cfg_size = '0; cfg_perm = '0; fault_clr = 1'b0;
    acc_valid = '0; acc_addr = '0; acc_wr = '0; acc_priv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: no region enabled after reset
    drive(0, 1'b0, 32'h0000_0010, 1'b0, 1'b0);
    #1;
    check("R10", {31'b0, allow[0]}, 32'd0);
    check("R10", {31'b0, fault_valid}, 32'd0);

    cfg(0, 32'h0000_0000, 5'd16, 4'b1111);
    cfg(1, 32'h0000_1000, 5'd12, 4'b0101);
    cfg(2, 32'h2000_0000, 5'd8,  4'b0011);
    cfg(5, 32'h0000_1800, 5'd11, 4'b1111);
    cfg(6, 32'h5000_0000, 5'd2,  4'b1111);
    cfg(7, 32'h4000_0000, 5'd5,  4'b0001);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(0, 1'b0, VEC[i][34:3], VEC[i][2], VEC[i][1]);
      #1;
      check(VREQ[i], {31'b0, allow[0]}, {31'b0, VEC[i][0]});
    end

    // R6: background map
    @(negedge clk);
    bg_en = 1'b1;
    drive(0, 1'b0, 32'h2000_0100, 1'b0, 1'b1);
    #1; check("R6", {31'b0, allow[0]}, 32'd1);
    drive(0, 1'b0, 32'h2000_0100, 1'b0, 1'b0);
    #1; check("R6", {31'b0, allow[0]}, 32'd0);
    bg_en = 1'b0;

    // R7: disabled unit
    @(negedge clk);
    mpu_en = 1'b0;
    drive(0, 1'b1, 32'h2000_0100, 1'b1, 1'b0);
    drive(1, 1'b1, 32'h0000_1004, 1'b1, 1'b0);
    drive(2, 1'b1, 32'h9000_0000, 1'b0, 1'b0);
    #1; check("R7", {29'b0, allow}, 32'd7);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    @(negedge clk);
    check("R7", {31'b0, fault_valid}, 32'd0);
    mpu_en = 1'b1;

    // R11: independent buses
    drive(0, 1'b0, 32'h0000_0010, 1'b1, 1'b0);
    drive(1, 1'b0, 32'h2000_0010, 1'b1, 1'b1);
    drive(2, 1'b0, 32'h2000_0010, 1'b1, 1'b0);
    #1; check("R11", {29'b0, allow}, 32'b011);

    // R8: two buses fault, lowest recorded
    @(negedge clk);
    drive(0, 1'b1, 32'h0000_0020, 1'b0, 1'b0);
    drive(1, 1'b1, 32'h2000_0100, 1'b0, 1'b0);
    drive(2, 1'b1, 32'h0000_1004, 1'b1, 1'b1);
    @(negedge clk);
    check("R8", {31'b0, fault_valid}, 32'd1);
    check("R8", fault_addr, 32'h2000_0100);
    check("R8", {31'b0, fault_wr}, 32'd0);
    check("R8", {30'b0, fault_port}, 32'd1);

    // R9: hold against later fault
    drive(1, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(0, 1'b1, 32'h0000_17FC, 1'b1, 1'b0);
    drive(2, 1'b0, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    check("R9", fault_addr, 32'h2000_0100);
    check("R9", {30'b0, fault_port}, 32'd1);

    // R9: clear without new fault
    drive(0, 1'b0, 32'h0, 1'b0, 1'b0);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    check("R9", {31'b0, fault_valid}, 32'd0);

    // R9: capture a fault first, then clear together with a new one
    drive(2, 1'b1, 32'h4000_0020, 1'b1, 1'b1);
    @(negedge clk);
    check("R8", {30'b0, fault_port}, 32'd2);
    drive(2, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(0, 1'b1, 32'h0000_1008, 1'b1, 1'b0);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    drive(0, 1'b0, 32'h0, 1'b0, 1'b0);
    check("R9", {31'b0, fault_valid}, 32'd1);
    check("R9", fault_addr, 32'h0000_1008);
    check("R9", {31'b0, fault_wr}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule